// File: doc/BRIEF.md
# Parallel Panel Command Bridge

This block lets a processor reach a display panel that keeps its own frame memory, over an 8080-style parallel bus. Each transfer is a single bus word. Software first loads a staging register. Bit 24 of the staged word sets the level of the register-select (RS) line: low marks a command index and high marks parameter data. Software then writes a trigger register. The trigger starts the bus cycle and picks one of two panels, the main panel or the sub panel. Reads follow the same two-step pattern through a separate readback register and read trigger, and they return an 18-bit value.

Each bus cycle has three phases: a setup phase, a strobe-low phase and a hold phase. Each phase lasts a parameterised number of clock cycles. A busy bit in the status register stays set for the whole cycle. Software polls it before it issues the next access.

The register interface is a simple single-cycle port. Writes take effect on the clock edge. Reads are combinational from the address. The register offsets are: stage = 0, write trigger = 1, readback = 2, read trigger = 3, status = 4.

Top module: `pbr_bridge`

## Requirements
- R1: After reset, both panel selects, the write strobe and the read strobe are high, the data bus is released, and the status and readback registers read 0.
- R2: While a cycle is active, RS equals bit 24 of the word that was used. For a write, that word is the staged word, so bit 24 clear gives a command index (RS low) and bit 24 set gives parameter data (RS high). For a read, it is the readback register's bit 24. RS idles high.
- R3: A write to offset 1 or offset 3 with bit 0 set starts a cycle. Bit 1 of that write selects the panel: 1 drives panel select [1] (sub) low, and 0 drives panel select [0] (main) low. A trigger with bit 0 clear does nothing.
- R4: Status bit 1 (busy) reads 1 from the cycle after an accepted trigger, for exactly T_SU+T_PW+T_HD cycles, and then reads 0. All other status bits read 0.
- R5: In a write cycle, the panel select and RS are valid for T_SU cycles before the write strobe falls. The write strobe stays low for T_PW cycles and is followed by T_HD hold cycles before the select is released.
- R6: The data bus enable is high for the whole of a write cycle, and the bus carries bits 17:0 of the staged word. The enable is low at all other times.
- R7: A read cycle drives the read strobe low for T_PW cycles after T_SU setup cycles, with the data bus released. The panel input is captured on the clock edge where the read strobe rises. After busy clears, bits 17:0 of the readback register hold that value.
- R8: A trigger written while busy is 1 is ignored. The active cycle keeps its panel, RS level and length, and no second cycle follows.
- R9: At most one panel select and at most one strobe are low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| pnl_cs_n | output | 2 | Panel selects, [0] main, [1] sub, active low |
| pnl_rs | output | 1 | Register-select line: low command, high data |
| pnl_wr_n | output | 1 | Write strobe, active low |
| pnl_rd_n | output | 1 | Read strobe, active low |
| pnl_db_o | output | 18 | Data bus output value |
| pnl_db_oe | output | 1 | Data bus output enable |
| pnl_db_i | input | 18 | Data bus input value |

## Verification
The assertions assume that the panel input is stable around the clock edge that captures it. They also assume that software writes only one register per cycle. The bench drives every input on the falling clock edge, so each value is settled before the capture edge. It changes the panel input every cycle, so a capture taken one cycle early or late shows up in the readback value. It also writes both triggers and the stage register while a cycle is active, so the cases that must be ignored are exercised.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    localparam int REG_STAGE = 0;
    localparam int REG_GO_WR = 1;
    localparam int REG_RDBK  = 2;
    localparam int REG_GO_RD = 3;
    localparam int REG_STAT  = 4;

    localparam int RS_BIT   = 24;
    localparam int GO_BIT   = 0;
    localparam int SEL_BIT  = 1;
    localparam int BUSY_BIT = 1;
endpackage

// File: rtl/pbr_regs.sv
module pbr_regs
    import pbr_pkg::*;
#(
    parameter int AW   = 3,
    parameter int DB_W = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic            busy,
    input  logic            smp_en,
    input  logic [DB_W-1:0] pnl_db_i,
    output logic            go,
    output logic            go_rd,
    output logic            go_sel,
    output logic            go_rs,
    output logic [DB_W-1:0] go_data
);
    typedef struct packed {
        logic [31:0]     stage;
        logic            rd_rs;
        logic [DB_W-1:0] sample;
    } regs_t;

    regs_t r_d, r_q;
    logic  hit_wr, hit_rd;

    always_comb begin
        r_d    = r_q;
        hit_wr = bus_we && (bus_addr == AW'(REG_GO_WR)) && bus_wdata[GO_BIT] && !busy;
        hit_rd = bus_we && (bus_addr == AW'(REG_GO_RD)) && bus_wdata[GO_BIT] && !busy;
        if (bus_we && (bus_addr == AW'(REG_STAGE))) r_d.stage = bus_wdata;
        if (bus_we && (bus_addr == AW'(REG_RDBK)))  r_d.rd_rs = bus_wdata[RS_BIT];
        if (smp_en) r_d.sample = pnl_db_i;
        go      = hit_wr || hit_rd;
        go_rd   = hit_rd;
        go_sel  = bus_wdata[SEL_BIT];
        go_rs   = hit_rd ? r_q.rd_rs : r_q.stage[RS_BIT];
        go_data = r_q.stage[DB_W-1:0];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(REG_STAGE)) begin
            bus_rdata = r_q.stage;
        end else if (bus_addr == AW'(REG_RDBK)) begin
            bus_rdata[DB_W-1:0] = r_q.sample;
            bus_rdata[RS_BIT]   = r_q.rd_rs;
        end else if (bus_addr == AW'(REG_STAT)) begin
            bus_rdata[BUSY_BIT] = busy;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R7: the capture edge stores the panel value present at that edge
    p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        smp_en |=> (r_q.sample == $past(pnl_db_i)));
endmodule

// File: rtl/pbr_seq.sv
module pbr_seq
    import pbr_pkg::*;
#(
    parameter int DB_W = 18,
    parameter int T_SU = 2,
    parameter int T_PW = 3,
    parameter int T_HD = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            go_rd,
    input  logic            go_sel,
    input  logic            go_rs,
    input  logic [DB_W-1:0] go_data,
    output logic            busy,
    output logic            smp_en,
    output phase_e          ph,
    output logic            cyc_rd,
    output logic            cyc_sel,
    output logic            cyc_rs,
    output logic [DB_W-1:0] cyc_data
);
    localparam int SU_C = (T_SU < 1) ? 1 : ((T_SU > 15) ? 15 : T_SU);
    localparam int PW_C = (T_PW < 1) ? 1 : ((T_PW > 15) ? 15 : T_PW);
    localparam int HD_C = (T_HD < 1) ? 1 : ((T_HD > 15) ? 15 : T_HD);
    localparam logic [3:0] SU_L = 4'(SU_C - 1);
    localparam logic [3:0] PW_L = 4'(PW_C - 1);
    localparam logic [3:0] HD_L = 4'(HD_C - 1);

    typedef struct packed {
        phase_e          ph;
        logic [3:0]      cnt;
        logic            rd;
        logic            sel;
        logic            rs;
        logic [DB_W-1:0] data;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        smp_en = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (go) begin
                    s_d.ph   = PH_SETUP;
                    s_d.cnt  = SU_L;
                    s_d.rd   = go_rd;
                    s_d.sel  = go_sel;
                    s_d.rs   = go_rs;
                    s_d.data = go_data;
                end
            end
            PH_SETUP: begin
                if (s_q.cnt == 4'd0) begin
                    s_d.ph  = PH_STROBE;
                    s_d.cnt = PW_L;
                end else begin
                    s_d.cnt = s_q.cnt - 4'd1;
                end
            end
            PH_STROBE: begin
                if (s_q.cnt == 4'd0) begin
                    s_d.ph  = PH_HOLD;
                    s_d.cnt = HD_L;
                    smp_en  = s_q.rd;
                end else begin
                    s_d.cnt = s_q.cnt - 4'd1;
                end
            end
            PH_HOLD: begin
                if (s_q.cnt == 4'd0) s_d.ph = PH_IDLE;
                else                 s_d.cnt = s_q.cnt - 4'd1;
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: PH_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign busy     = (s_q.ph != PH_IDLE);
    assign ph       = s_q.ph;
    assign cyc_rd   = s_q.rd;
    assign cyc_sel  = s_q.sel;
    assign cyc_rs   = s_q.rs;
    assign cyc_data = s_q.data;

    // R8: once a cycle runs, its target, direction and RS level stay fixed until idle
    p_target_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph != PH_IDLE) |=> (s_q.ph == PH_IDLE) ||
            ($stable(s_q.sel) && $stable(s_q.rs) && $stable(s_q.rd)));

    // R5: the strobe phase is always entered from the setup phase
    p_setup_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.ph == PH_STROBE) |-> ($past(s_q.ph) == PH_SETUP));
endmodule

// File: rtl/pbr_pins.sv
module pbr_pins
    import pbr_pkg::*;
#(
    parameter int DB_W  = 18,
    parameter int N_PNL = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_e           ph,
    input  logic             cyc_rd,
    input  logic             cyc_sel,
    input  logic             cyc_rs,
    input  logic [DB_W-1:0]  cyc_data,
    output logic [N_PNL-1:0] pnl_cs_n,
    output logic             pnl_rs,
    output logic             pnl_wr_n,
    output logic             pnl_rd_n,
    output logic [DB_W-1:0]  pnl_db_o,
    output logic             pnl_db_oe
);
    logic active;

    assign active = (ph != PH_IDLE);

    for (genvar g = 0; g < N_PNL; g++) begin : g_cs
        assign pnl_cs_n[g] = !(active && (cyc_sel == 1'(g)));
    end

    always_comb begin
        pnl_rs    = active ? cyc_rs : 1'b1;
        pnl_wr_n  = !((ph == PH_STROBE) && !cyc_rd);
        pnl_rd_n  = !((ph == PH_STROBE) && cyc_rd);
        pnl_db_oe = active && !cyc_rd;
        pnl_db_o  = pnl_db_oe ? cyc_data : '0;
    end

    // R9: never both strobes low
    p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!pnl_wr_n && !pnl_rd_n));

    // R9: never more than one panel selected
    p_one_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~pnl_cs_n) <= 1);

    // R6: bus released while the read strobe is low
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pnl_rd_n |-> !pnl_db_oe);

    // R5: a strobe is only low inside a selected cycle
    p_cs_cover_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pnl_wr_n || !pnl_rd_n) |-> (pnl_cs_n != '1));
endmodule

// File: rtl/pbr_bridge.sv
module pbr_bridge
    import pbr_pkg::*;
#(
    parameter int AW   = 3,
    parameter int DB_W = 18,
    parameter int T_SU = 2,
    parameter int T_PW = 3,
    parameter int T_HD = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    output logic [1:0]      pnl_cs_n,
    output logic            pnl_rs,
    output logic            pnl_wr_n,
    output logic            pnl_rd_n,
    output logic [DB_W-1:0] pnl_db_o,
    output logic            pnl_db_oe,
    input  logic [DB_W-1:0] pnl_db_i
);
    logic            busy, smp_en, go, go_rd, go_sel, go_rs;
    logic [DB_W-1:0] go_data, cyc_data;
    logic            cyc_rd, cyc_sel, cyc_rs;
    phase_e          ph;

    pbr_regs #(.AW(AW), .DB_W(DB_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .smp_en(smp_en), .pnl_db_i(pnl_db_i), .go(go), .go_rd(go_rd),
        .go_sel(go_sel), .go_rs(go_rs), .go_data(go_data)
    );

    pbr_seq #(.DB_W(DB_W), .T_SU(T_SU), .T_PW(T_PW), .T_HD(T_HD)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .go_rd(go_rd), .go_sel(go_sel),
        .go_rs(go_rs), .go_data(go_data), .busy(busy), .smp_en(smp_en),
        .ph(ph), .cyc_rd(cyc_rd), .cyc_sel(cyc_sel), .cyc_rs(cyc_rs),
        .cyc_data(cyc_data)
    );

    pbr_pins #(.DB_W(DB_W), .N_PNL(2)) u_pins (
        .clk(clk), .rst_n(rst_n), .ph(ph), .cyc_rd(cyc_rd), .cyc_sel(cyc_sel),
        .cyc_rs(cyc_rs), .cyc_data(cyc_data), .pnl_cs_n(pnl_cs_n),
        .pnl_rs(pnl_rs), .pnl_wr_n(pnl_wr_n), .pnl_rd_n(pnl_rd_n),
        .pnl_db_o(pnl_db_o), .pnl_db_oe(pnl_db_oe)
    );
endmodule

// File: tb/sim_pbr_bridge.sv
`timescale 1ns/1ps
module sim_pbr_bridge;
    localparam int TSU = 2;
    localparam int TPW = 3;
    localparam int THD = 2;
    localparam int TOT = TSU + TPW + THD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd4;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  pnl_cs_n;
    logic        pnl_rs, pnl_wr_n, pnl_rd_n, pnl_db_oe;
    logic [17:0] pnl_db_o;
    logic [17:0] pnl_db_i = '0;

    int vectors = 0;
    int errs = 0;
    int cyc = 0;
    bit done = 0;

    // reference model state
    bit          m_busy = 0;
    int          m_k = 0;
    bit          m_sel = 0, m_rs = 0, m_rd = 0, m_rdflag = 0;
    logic [17:0] m_data = '0, m_sample = '0;
    logic [31:0] m_stage = '0;

    always #2.5 clk = ~clk;

    pbr_bridge #(.T_SU(TSU), .T_PW(TPW), .T_HD(THD)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pnl_cs_n(pnl_cs_n),
        .pnl_rs(pnl_rs), .pnl_wr_n(pnl_wr_n), .pnl_rd_n(pnl_rd_n),
        .pnl_db_o(pnl_db_o), .pnl_db_oe(pnl_db_oe), .pnl_db_i(pnl_db_i)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // changing panel input so an off-by-one capture is visible
    always @(negedge clk) begin
        cyc++;
        pnl_db_i <= 18'(cyc * 32'h2F1B + 7);
    end

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_k = 0; m_sel = 0; m_rs = 0; m_rd = 0;
            m_rdflag = 0; m_data = '0; m_sample = '0; m_stage = '0;
        end else begin
            bit was_busy;
            was_busy = m_busy;
            if (m_busy) begin
                if (m_rd && m_k == TSU + TPW - 1) m_sample = pnl_db_i;
                m_k++;
                if (m_k == TOT) m_busy = 0;
            end
            if (bus_we) begin
                if (bus_addr == 3'd0) m_stage = bus_wdata;
                if (bus_addr == 3'd2) m_rdflag = bus_wdata[24];
                if (!was_busy && bus_wdata[0] && (bus_addr == 3'd1 || bus_addr == 3'd3)) begin
                    m_busy = 1; m_k = 0; m_sel = bus_wdata[1];
                    m_rd = (bus_addr == 3'd3);
                    m_rs = m_rd ? m_rdflag : m_stage[24];
                    m_data = m_stage[17:0];
                end
            end
        end
    end

    // compare on every clock, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            logic [1:0]  e_cs;
            logic        e_strobe;
            logic [31:0] e_rd;
            e_cs = 2'b11;
            if (m_busy) e_cs[m_sel] = 1'b0;
            e_strobe = m_busy && (m_k >= TSU) && (m_k < TSU + TPW);
            chk("R3", 32'(pnl_cs_n), 32'(e_cs));
            chk("R2", 32'(pnl_rs), 32'(m_busy ? m_rs : 1'b1));
            chk("R5", 32'(pnl_wr_n), 32'(!(e_strobe && !m_rd)));
            chk("R7", 32'(pnl_rd_n), 32'(!(e_strobe && m_rd)));
            chk("R6", 32'(pnl_db_oe), 32'(m_busy && !m_rd));
            if (pnl_db_oe) chk("R6", 32'(pnl_db_o), 32'(m_data));
            chk("R9", 32'($countones(~pnl_cs_n) <= 1 && (pnl_wr_n || pnl_rd_n)), 32'd1);
            e_rd = '0;
            case (bus_addr)
                3'd0: e_rd = m_stage;
                3'd2: begin e_rd[17:0] = m_sample; e_rd[24] = m_rdflag; end
                3'd4: e_rd[1] = m_busy;
                default: e_rd = '0;
            endcase
            if (bus_addr == 3'd4) chk("R4", bus_rdata, e_rd);
            else                  chk("R7", bus_rdata, e_rd);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 3'd4; bus_wdata = '0;
    endtask

    task automatic wait_idle();
        while (m_busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic peek(input logic [2:0] a);
        @(negedge clk);
        bus_addr = a;
        repeat (2) @(negedge clk);
        bus_addr = 3'd4;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the pins and registers
        chk("R1", 32'(pnl_cs_n), 32'd3);
        chk("R1", 32'({pnl_wr_n, pnl_rd_n, pnl_db_oe}), 32'b110);
        chk("R1", bus_rdata, 32'd0);
        bus_addr = 3'd2; #0.1;
        chk("R1", bus_rdata, 32'd0);
        bus_addr = 3'd4;
        rst_n = 1'b1;

        // R2 command index to main panel
        wr(3'd0, 32'h1000_0055);
        wr(3'd1, 32'h0000_0001);
        wait_idle();
        // R2 parameter data to sub panel; R8 triggers and stage write while busy
        wr(3'd0, 32'h1100_3ABC);
        wr(3'd1, 32'h0000_0003);
        wr(3'd1, 32'h0000_0001);
        chk("R8", 32'(pnl_cs_n), 32'b01);
        wr(3'd3, 32'h0000_0001);
        wr(3'd0, 32'h1100_0123);
        wait_idle();
        peek(3'd0);
        // R3 trigger with bit 0 clear does nothing
        wr(3'd1, 32'h0000_0002);
        repeat (3) @(negedge clk);
        chk("R3", 32'(pnl_cs_n), 32'd3);
        // R7 read from sub panel with RS high
        wr(3'd2, 32'h0100_0000);
        wr(3'd3, 32'h0000_0003);
        wait_idle();
        peek(3'd2);
        // R7 read from main panel with RS low
        wr(3'd2, 32'h0000_0000);
        wr(3'd3, 32'h0000_0001);
        wait_idle();
        peek(3'd2);
        // back-to-back writes: R5 R6 timing repeated
        wr(3'd0, 32'h1100_2AAA);
        wr(3'd1, 32'h0000_0001);
        wait_idle();
        wr(3'd1, 32'h0000_0003);
        wait_idle();
        repeat (4) @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errs++;
            $display("FAIL watchdog expired, run hung");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end
endmodule